// File: doc/BRIEF.md
# Tick Interrupt Timer

This block raises a periodic interrupt for a real-time clock subsystem. A 32768 Hz reference arrives as a one-cycle enable pulse on the system clock. A programmable power-of-two prescaler divides it down, and a down-counter that reloads from a software-set count divides it further. Each time the down-counter runs out, a sticky pending flag is set and the interrupt line goes high. Software clears the flag by writing a one to it.

Software controls the block through a small strobe bus: a write strobe with address and data, and a read strobe that returns the addressed register one cycle later. The counter starts only on a rising edge of the tick enable inside a control write. That write must also leave the global enable set, and the tick count must be non-zero. The counter stops when either enable is withdrawn. Count values that are too small to give a sensible period are refused, and the register keeps its old value.

Top module: `rtc_tick_timer`

## Requirements
- R1: After a synchronous reset every register reads zero, `tick_irq` is low and the down-counter is stopped. The register addresses are: 0 control, 1 tick count, 2 pending, 3 current count.
- R2: The control field [7:4] holds `sel`. While the counter runs, it decrements by one once every 2^sel reference pulses, counted from the start.
- R3: The counter loads the tick count and clears the prescaler phase when a control write meets three conditions: it sets bit 0 (global enable), it changes bit 8 (tick enable) from 0 to 1, and the stored tick count is non-zero.
- R4: A running counter expires when a decrement finds it at 1. Expiry sets pending bit 0, drives `tick_irq` high, reloads the tick count and keeps counting. With count N, one period is therefore N*2^sel reference pulses.
- R5: A write to the pending register with bit 0 set clears the flag and lowers `tick_irq`. A write with bit 0 clear changes nothing. An expiry in the same cycle as a clearing write wins.
- R6: A write to the tick count register with a value of 2 or less leaves the register unchanged. A larger value is stored.
- R7: The counter stops, holding its value, in two cases. The first is a control write that clears bit 8 while bit 0 stays set. The second is a control write that clears bit 0 while it was set.
- R8: Reading address 3 returns the live down-counter value. Read data for any address appears one cycle after the read strobe.
- R9: No start occurs in three cases: the tick count is zero, bit 0 is clear in the write, or bit 8 was already set before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-cycle 32768 Hz reference enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| tick_irq | output | 1 | Tick interrupt, level, follows pending bit 0 |

## Verification
Two situations are hard to reach: an enable that is already set when the other one rises, and a stop with a partly consumed count. Neither is visible unless the counter value is read after further reference pulses. The bench starts the counter and spends one decrement. It then withdraws each enable in turn, issues more pulses, and reads the current count to show that it stayed frozen. It then re-raises the global enable with the tick enable still set, and checks through the same readback that no reload happened. Periods are checked one pulse before expiry and at expiry, over several select and count pairs.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    localparam int CTRL_GEN_BIT  = 0;
    localparam int CTRL_SEL_LSB  = 4;
    localparam int CTRL_SEL_W    = 4;
    localparam int CTRL_TICK_BIT = 8;
    localparam int MIN_COUNT     = 2;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_PEND  = 2'd2,
        REG_CURR  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                  tick_en;
        logic [CTRL_SEL_W-1:0] sel;
        logic                  gen_en;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
    } cmd_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.gen_en  = w[CTRL_GEN_BIT];
        c.sel     = w[CTRL_SEL_LSB +: CTRL_SEL_W];
        c.tick_en = w[CTRL_TICK_BIT];
        return c;
    endfunction

    function automatic logic [31:0] encode_ctrl(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CTRL_GEN_BIT]                   = c.gen_en;
        w[CTRL_SEL_LSB +: CTRL_SEL_W]     = c.sel;
        w[CTRL_TICK_BIT]                  = c.tick_en;
        return w;
    endfunction

endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import rtc_tick_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] tcount,
    output logic              pend,
    output cmd_t              cmd
);

    ctrl_t ctrl_new;
    logic  wr_ctrl, wr_count, wr_pend;

    assign ctrl_new = decode_ctrl(wdata);
    assign wr_ctrl  = wr_en && (addr == REG_CTRL);
    assign wr_count = wr_en && (addr == REG_COUNT);
    assign wr_pend  = wr_en && (addr == REG_PEND);

    always_comb begin
        cmd.start = wr_ctrl && ctrl_new.gen_en && ctrl_new.tick_en &&
                    !ctrl.tick_en && (tcount != '0);
        cmd.stop  = wr_ctrl &&
                    ((ctrl.gen_en && !ctrl_new.gen_en) ||
                     (ctrl_new.gen_en && ctrl.tick_en && !ctrl_new.tick_en));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            tcount <= '0;
            pend   <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_new;
            if (wr_count && (wdata[DATA_W-1:0] > DATA_W'(MIN_COUNT)))
                tcount <= wdata[DATA_W-1:0];
            if (expire)
                pend <= 1'b1;
            else if (wr_pend && wdata[0])
                pend <= 1'b0;
        end
    end

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             dec_pulse
);

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] mask;

    // Bit i of the mask is set when i lies below the select value.
    generate
        for (genvar i = 0; i < PRE_W; i++) begin : g_mask
            assign mask[i] = (SEL_W'(i) < sel);
        end
    endgenerate

    assign dec_pulse = ref_pulse && ((phase & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase <= '0;
        else if (ref_pulse)
            phase <= phase + 1'b1;
    end

endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              dec,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] cur,
    output logic              running,
    output logic              expire
);

    logic step;

    assign step   = running && dec && !start && !stop;
    assign expire = step && (cur == DATA_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cur     <= reload;
            running <= 1'b1;
        end else if (stop) begin
            running <= 1'b0;
        end else if (expire) begin
            cur <= reload;
        end else if (step) begin
            cur <= cur - 1'b1;
        end
    end

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
    import rtc_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_pulse,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        tick_irq
);

    localparam int SEL_W = CTRL_SEL_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] tcount_q;
    logic              pend_q;
    cmd_t              cmd;
    logic              dec_pulse;
    logic [DATA_W-1:0] cur_cnt;
    logic              running;
    logic              expire;
    logic [31:0]       rd_mux;

    tick_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .expire (expire),
        .ctrl   (ctrl_q),
        .tcount (tcount_q),
        .pend   (pend_q),
        .cmd    (cmd)
    );

    tick_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .clear     (cmd.start),
        .sel       (ctrl_q.sel),
        .dec_pulse (dec_pulse)
    );

    tick_downcounter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .start   (cmd.start),
        .stop    (cmd.stop),
        .dec     (dec_pulse),
        .reload  (tcount_q),
        .cur     (cur_cnt),
        .running (running),
        .expire  (expire)
    );

    always_comb begin
        unique case (reg_addr_e'(addr))
            REG_CTRL:  rd_mux = encode_ctrl(ctrl_q);
            REG_COUNT: rd_mux = 32'(tcount_q);
            REG_PEND:  rd_mux = {31'd0, pend_q};
            REG_CURR:  rd_mux = 32'(cur_cnt);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign tick_irq = pend_q;

endmodule

// File: rtl/rtc_tick_checker.sv
module rtc_tick_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [31:0]       wdata,
    input logic              tick_irq,
    input logic [DATA_W-1:0] tcount,
    input logic [DATA_W-1:0] cur,
    input logic              running,
    input logic              expire,
    input logic              gen_en
);

    // R6
    count_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (tcount == '0) || (tcount > DATA_W'(2)));

    // R6
    count_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && wdata <= 32'd2) |=> $stable(tcount));

    // R4
    expire_irq_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> tick_irq);

    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(tick_irq) && !$past(rst)) |->
            $past(wr_en && addr == 2'd2 && wdata[0]));

    // R7
    gen_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && gen_en && !wdata[0]) |=> !running);

    // R3
    run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (cur != '0));

endmodule

bind rtc_tick_timer rtc_tick_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .tick_irq (tick_irq),
    .tcount   (tcount_q),
    .cur      (cur_cnt),
    .running  (running),
    .expire   (expire),
    .gen_en   (ctrl_q.gen_en)
);

// File: tb/rtc_tick_timer_test.sv
module rtc_tick_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_pulse = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rtc_tick_timer uut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .tick_irq(tick_irq)
    );

    // {sel[15:12], count[11:0]}
    localparam logic [15:0] VEC [6] = '{
        {4'd0, 12'd3}, {4'd1, 12'd4}, {4'd2, 12'd5},
        {4'd3, 12'd3}, {4'd0, 12'd9}, {4'd4, 12'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0;
        end
    endtask

    task automatic start_run(input logic [3:0] sel, input logic [31:0] n);
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h1);
        wr(2'd1, n);
        wr(2'd0, {23'd0, 1'b1, sel, 3'd0, 1'b1});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'd0, tick_irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 32'd0);
        end

        // R9 zero count: no start
        wr(2'd0, 32'h101);
        pulses(6);
        rd(2'd3, d);
        chk("R9 zero count", d, 32'd0);
        chk("R9 zero count irq", {31'd0, tick_irq}, 32'd0);

        // R2 R4 R8 vector walk
        foreach (VEC[k]) begin
            int sel = int'(VEC[k][15:12]);
            int n   = int'(VEC[k][11:0]);
            int per = n << sel;
            start_run(4'(sel), 32'(n));
            rd(2'd3, d);
            chk("R3 loaded", d, 32'(n));
            pulses(per - 1);
            chk("R2 early irq", {31'd0, tick_irq}, 32'd0);
            rd(2'd3, d);
            chk("R8 live count", d, 32'd1);
            pulses(1);
            chk("R4 expiry irq", {31'd0, tick_irq}, 32'd1);
            rd(2'd3, d);
            chk("R4 reload", d, 32'(n));
            wr(2'd2, 32'h1);
            chk("R5 clear", {31'd0, tick_irq}, 32'd0);
            pulses(per);
            chk("R4 keeps running", {31'd0, tick_irq}, 32'd1);
        end

        // R6 small count writes ignored
        wr(2'd1, 32'd7);
        wr(2'd1, 32'd2);
        rd(2'd1, d);
        chk("R6 write 2", d, 32'd7);
        wr(2'd1, 32'd0);
        rd(2'd1, d);
        chk("R6 write 0", d, 32'd7);
        wr(2'd1, 32'd3);
        rd(2'd1, d);
        chk("R6 write 3", d, 32'd3);

        // R5 writing 0 has no effect
        start_run(4'd0, 32'd3);
        pulses(3);
        wr(2'd2, 32'h0);
        chk("R5 zero write irq", {31'd0, tick_irq}, 32'd1);
        rd(2'd2, d);
        chk("R5 zero write pend", d, 32'd1);
        wr(2'd2, 32'h1);
        rd(2'd2, d);
        chk("R5 w1c pend", d, 32'd0);

        // R7 tick enable falls with global enable held
        start_run(4'd0, 32'd3);
        pulses(1);
        wr(2'd0, 32'h1);
        pulses(5);
        rd(2'd3, d);
        chk("R7 tick stop", d, 32'd2);
        chk("R7 tick stop irq", {31'd0, tick_irq}, 32'd0);

        // R7 global enable falls
        start_run(4'd0, 32'd3);
        pulses(1);
        wr(2'd0, 32'h100);
        pulses(5);
        rd(2'd3, d);
        chk("R7 gen stop", d, 32'd2);

        // R9 global enable rises while tick enable already set
        wr(2'd0, 32'h101);
        pulses(5);
        rd(2'd3, d);
        chk("R9 gen rise", d, 32'd2);
        chk("R9 gen rise irq", {31'd0, tick_irq}, 32'd0);

        // R9 tick enable rises with global enable clear
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h100);
        pulses(5);
        rd(2'd3, d);
        chk("R9 gen clear", d, 32'd2);

        // R1 reset stops a running counter
        start_run(4'd0, 32'd5);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        pulses(8);
        rd(2'd3, d);
        chk("R1 reset stop", d, 32'd0);
        chk("R1 reset irq", {31'd0, tick_irq}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule